// File: doc/BRIEF.md
# Dual-Path Registered Bus Transceiver

This block links two 8-bit buses, called A and B, and moves data between them in either direction. Each direction has its own edge-triggered holding register with its own capture clock. A per-direction select chooses what goes out on the far bus: the live value on the near bus, or the value held in that direction's register. Each bus is presented as three separate signals: an input vector that carries the resolved line value, an output vector, and a single output-enable. The surrounding logic, or a testbench, combines these into the shared lines.

The direction from A to B drives when its enable is high. The direction from B to A drives when its enable is low. Both registers capture on every rising edge of their own clock, whatever the select and enable inputs are. With this, one direction can carry data out while the other direction is recording its own bus. It also lets a value crossing from A to B be written into both registers.

If both directions drive live data at the same time, each bus is fed back from the other. Once every outside driver lets go, the two buses keep their last value. The output path is purely combinational, so live transfers add no clock latency.

Top module: `dual_path_xcvr`

## Requirements
- R1: While `rst_n` is low at a rising edge of a direction's clock, that direction's register is cleared to 0. A later stored-mode read of that direction returns 0x00.
- R2: On each rising edge of `clk_ab`, the A-to-B register takes the value of `a_in`. This happens for every setting of the selects and enables.
- R3: On each rising edge of `clk_ba`, the B-to-A register takes the value of `b_in`. This happens for every setting of the selects and enables.
- R4: When a select is 0 (live), the output toward the far bus equals the near bus input in the same cycle, with no register in between: `b_out` follows `a_in` and `a_out` follows `b_in`.
- R5: When a select is 1 (stored), the output toward the far bus equals that direction's register: `b_out` shows the A-to-B register and `a_out` shows the B-to-A register.
- R6: `b_oe` is 1 exactly when `en_ab` is 1. The enable is active high.
- R7: `a_oe` is 1 exactly when `en_ba_n` is 0. The enable is active low.
- R8: With `en_ab`=0 and `en_ba_n`=1, the block drives neither bus. Each bus then takes only the outside driver's value, with no contention.
- R9: With both selects at 0 and both directions enabled, once the outside drivers let go, each bus keeps the value it carried just before.
- R10: With `en_ab`=1, `en_ba_n`=1 and `sel_ab`=0, an edge on `clk_ba` loads A's data into the B-to-A register. With `en_ab`=0, `en_ba_n`=0 and `sel_ba`=0, an edge on `clk_ab` loads B's data into the A-to-B register.
- R11: When the live value and the stored value are equal, switching a select between 0 and 1 leaves the driven output unchanged.
- R12: With both buses driven from outside, rising edges on both clocks at the same time load each register with its own bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| rst_n | input | 1 | Active-low reset, synchronous to each capture clock |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| en_ab | input | 1 | A-to-B output enable, active high |
| en_ba_n | input | 1 | B-to-A output enable, active low |
| a_in | input | 8 | Resolved value on bus A |
| a_out | output | 8 | Value the block would drive on bus A |
| a_oe | output | 1 | Block drives bus A |
| b_in | input | 8 | Resolved value on bus B |
| b_out | output | 8 | Value the block would drive on bus B |
| b_oe | output | 1 | Block drives bus B |

## Verification
Live transfer is tried with 0x00, 0xFF, 0x5A and 0x81 in both directions. All-zero and all-one patterns show whether any bit is stuck. The alternating pattern and the two-ended pattern show whether bits are swapped, and whether a register stage has crept into the path. Stored transfer uses values different from what is on the live bus, so that a swapped mux selection shows up. Captures are done with one clock alone, with both clocks together, and in the two pass-through setups that load one bus into both registers. Each of these separates which register saw which edge. The bus-hold case compares the lines before and after the outside drivers let go.

// File: rtl/xcvr_pkg.sv
// Shared types for the dual-path transceiver.
package xcvr_pkg;

    // Source choice for one direction's outgoing data.
    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } src_sel_e;

    // Index of each direction in the per-direction arrays.
    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;

endpackage

// File: rtl/capture_reg.sv
// Edge-triggered holding register for one transfer direction.
// Captures its data input on every rising clock edge, whatever the selects
// and enables are. Assumes rst_n is held long enough to span a clock edge.
module capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Clear on reset, otherwise load the bus value on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (q == '0));

    // R2 R3
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (q == $past(d)));

endmodule

// File: rtl/path_mux.sv
// Output source selector for one direction: live bus data or held data.
// Purely combinational, so a live transfer adds no clock latency. Assumes
// the select is a plain level with no decoding between choices.
module path_mux
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  src_sel_e         sel,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] y
);

    // Per-bit AND-OR selection: equal inputs give the same output whatever the select.
    always_comb begin
        y = ({WIDTH{sel == SRC_LIVE}} & live) | ({WIDTH{sel == SRC_HELD}} & held);
    end

endmodule

// File: rtl/drive_ctl.sv
// Decodes the two direction enables into per-bus drive flags.
// The A-to-B enable is active high and the B-to-A enable is active low.
module drive_ctl (
    input  logic en_ab,
    input  logic en_ba_n,
    output logic a_oe,
    output logic b_oe
);

    // Map enable polarities onto the bus drive flags.
    always_comb begin
        b_oe = en_ab;
        a_oe = ~en_ba_n;
    end

endmodule

// File: rtl/dual_path_xcvr.sv
// Registered bidirectional transceiver between buses A and B.
// Each direction has a capture register on its own clock and a source mux,
// and the enables choose which bus the block drives. The bus lines are
// resolved outside; a_in and b_in carry the resolved line values.
module dual_path_xcvr
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst_n,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             en_ab,
    input  logic             en_ba_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    localparam int NDIR = 2;

    logic             dir_clk  [NDIR];
    src_sel_e         dir_sel  [NDIR];
    logic [WIDTH-1:0] dir_src  [NDIR];
    logic [WIDTH-1:0] dir_held [NDIR];
    logic [WIDTH-1:0] dir_y    [NDIR];

    // Gather the per-direction inputs into arrays.
    assign dir_clk[DIR_AB] = clk_ab;
    assign dir_clk[DIR_BA] = clk_ba;
    assign dir_sel[DIR_AB] = src_sel_e'(sel_ab);
    assign dir_sel[DIR_BA] = src_sel_e'(sel_ba);
    assign dir_src[DIR_AB] = a_in;
    assign dir_src[DIR_BA] = b_in;

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        capture_reg #(.WIDTH(WIDTH)) u_reg (
            .clk   (dir_clk[g]),
            .rst_n (rst_n),
            .d     (dir_src[g]),
            .q     (dir_held[g])
        );

        path_mux #(.WIDTH(WIDTH)) u_mux (
            .sel  (dir_sel[g]),
            .live (dir_src[g]),
            .held (dir_held[g]),
            .y    (dir_y[g])
        );
    end

    drive_ctl u_drive (
        .en_ab   (en_ab),
        .en_ba_n (en_ba_n),
        .a_oe    (a_oe),
        .b_oe    (b_oe)
    );

    // Route each direction's selected data onto the far bus.
    assign b_out = dir_y[DIR_AB];
    assign a_out = dir_y[DIR_BA];

    // R4
    live_ab_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (en_ab && !sel_ab) |-> (b_out == a_in));

    // R5
    held_ab_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (en_ab && sel_ab) |-> (b_out == dir_held[DIR_AB]));

    // R6
    b_drive_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !en_ab |-> !b_oe);

    // R7
    a_drive_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
        en_ba_n |-> !a_oe);

    // R8
    isolate_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (!en_ab && en_ba_n) |-> !(a_oe || b_oe));

endmodule

// File: tb/dual_path_xcvr_tb_top.sv
// Directed bench: models the two shared buses, one task per scenario.
module dual_path_xcvr_tb_top;

    logic       clk;
    logic       clk_ab, clk_ba, rst_n;
    logic       sel_ab, sel_ba, en_ab, en_ba_n;
    logic [7:0] a_line, b_line, a_out, b_out;
    logic       a_oe, b_oe;
    logic [7:0] ext_a, ext_b;
    logic       ext_a_en, ext_b_en;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 0;

    dual_path_xcvr #(.WIDTH(8)) dut_i (
        .clk_ab (clk_ab), .clk_ba (clk_ba), .rst_n (rst_n),
        .sel_ab (sel_ab), .sel_ba (sel_ba),
        .en_ab (en_ab), .en_ba_n (en_ba_n),
        .a_in (a_line), .a_out (a_out), .a_oe (a_oe),
        .b_in (b_line), .b_out (b_out), .b_oe (b_oe)
    );

    initial clk = 0;
    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Resolve both buses from outside drivers, block drivers and line holding.
    task automatic settle();
        for (int i = 0; i < 4; i++) begin
            logic [7:0] na, nb;
            #1;
            if (ext_a_en && a_oe) check("R8 contention on A", a_out, ext_a);
            if (ext_b_en && b_oe) check("R8 contention on B", b_out, ext_b);
            na = ext_a_en ? ext_a : (a_oe ? a_out : a_line);
            nb = ext_b_en ? ext_b : (b_oe ? b_out : b_line);
            a_line = na;
            b_line = nb;
        end
    endtask

    task automatic pulse(input bit pa, input bit pb);
        #2;
        if (pa) clk_ab = 1;
        if (pb) clk_ba = 1;
        #5;
        clk_ab = 0;
        clk_ba = 0;
        #3;
        settle();
    endtask

    task automatic set_ctl(input bit sab, input bit sba, input bit eab, input bit ebn);
        sel_ab = sab; sel_ba = sba; en_ab = eab; en_ba_n = ebn;
    endtask

    task automatic drive(input bit ae, input logic [7:0] av, input bit be, input logic [7:0] bv);
        ext_a_en = ae; ext_a = av; ext_b_en = be; ext_b = bv;
    endtask

    // Read both registers out through stored-mode transfers.
    task automatic read_held(input string tag, input logic [7:0] exp_ab, input logic [7:0] exp_ba);
        drive(0, 8'h00, 0, 8'h00);
        set_ctl(1, 1, 1, 0);
        settle();
        check({tag, " stored A-to-B on bus B"}, b_line, exp_ab);
        check({tag, " stored B-to-A on bus A"}, a_line, exp_ba);
    endtask

    task automatic t_reset();
        rst_n = 0;
        drive(1, 8'hAA, 1, 8'h55);
        set_ctl(0, 0, 0, 1);
        settle();
        pulse(1, 1);
        rst_n = 1;
        read_held("R1 reset", 8'h00, 8'h00);
    endtask

    task automatic t_enables();
        drive(0, 8'h00, 0, 8'h00);
        set_ctl(0, 0, 1, 1);
        settle();
        check("R6 b_oe with en_ab=1", {7'd0, b_oe}, 8'd1);
        check("R7 a_oe with en_ba_n=1", {7'd0, a_oe}, 8'd0);
        set_ctl(0, 0, 0, 0);
        settle();
        check("R6 b_oe with en_ab=0", {7'd0, b_oe}, 8'd0);
        check("R7 a_oe with en_ba_n=0", {7'd0, a_oe}, 8'd1);
    endtask

    task automatic t_isolation();
        set_ctl(1, 1, 0, 1);
        drive(1, 8'h0F, 1, 8'hF0);
        settle();
        check("R8 no drive on A", {7'd0, a_oe}, 8'd0);
        check("R8 no drive on B", {7'd0, b_oe}, 8'd0);
        check("R8 bus A from outside", a_line, 8'h0F);
        check("R8 bus B from outside", b_line, 8'hF0);
    endtask

    task automatic t_live();
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h5A, 8'h81};
        for (int i = 0; i < 4; i++) begin
            set_ctl(0, 1, 1, 1);
            drive(1, pats[i], 0, 8'h00);
            settle();
            check("R4 live A to B", b_line, pats[i]);
            set_ctl(1, 0, 0, 0);
            drive(0, 8'h00, 1, ~pats[i]);
            settle();
            check("R4 live B to A", a_line, ~pats[i]);
        end
    endtask

    task automatic t_capture_single();
        set_ctl(0, 0, 0, 1);
        drive(1, 8'h11, 1, 8'h22);
        settle();
        pulse(1, 0);
        read_held("R2 clk_ab alone", 8'h11, 8'h00);
        set_ctl(1, 1, 1, 0);
        drive(0, 8'h00, 0, 8'h00);
        b_line = 8'h33;
        set_ctl(1, 1, 0, 0);
        settle();
        drive(0, 8'h00, 1, 8'h33);
        settle();
        pulse(0, 1);
        read_held("R3 clk_ba alone with A driven", 8'h11, 8'h33);
    endtask

    task automatic t_stored_vs_live();
        set_ctl(1, 0, 1, 1);
        drive(1, 8'h77, 0, 8'h00);
        settle();
        check("R5 stored A-to-B ignores live A", b_line, 8'h11);
        set_ctl(0, 1, 0, 0);
        drive(0, 8'h00, 1, 8'h99);
        settle();
        check("R5 stored B-to-A ignores live B", a_line, 8'h33);
    endtask

    task automatic t_both_from_a();
        set_ctl(0, 0, 1, 1);
        drive(1, 8'hA5, 0, 8'h00);
        settle();
        pulse(0, 1);
        read_held("R10 A into B-to-A reg", 8'h11, 8'hA5);
        set_ctl(0, 0, 0, 0);
        drive(0, 8'h00, 1, 8'h5A);
        settle();
        pulse(1, 0);
        read_held("R10 B into A-to-B reg", 8'h5A, 8'hA5);
    endtask

    task automatic t_simultaneous();
        set_ctl(0, 0, 0, 1);
        drive(1, 8'hC3, 1, 8'h3C);
        settle();
        pulse(1, 1);
        read_held("R12 simultaneous clocks", 8'hC3, 8'h3C);
    endtask

    task automatic t_glitchless();
        set_ctl(1, 0, 1, 1);
        drive(1, 8'hC3, 0, 8'h00);
        settle();
        check("R11 stored equals live", b_out, 8'hC3);
        sel_ab = 0;
        #1;
        check("R11 after switch to live", b_out, 8'hC3);
        sel_ab = 1;
        #1;
        check("R11 after switch back", b_out, 8'hC3);
    endtask

    task automatic t_hold();
        set_ctl(0, 0, 1, 1);
        drive(1, 8'h6E, 0, 8'h00);
        settle();
        drive(0, 8'h00, 0, 8'h00);
        en_ba_n = 0;
        settle();
        check("R9 bus A held", a_line, 8'h6E);
        check("R9 bus B held", b_line, 8'h6E);
        #20;
        settle();
        check("R9 bus A still held", a_line, 8'h6E);
        check("R9 bus B still held", b_line, 8'h6E);
    endtask

    task automatic t_reset_again();
        set_ctl(0, 0, 0, 1);
        drive(1, 8'hEE, 1, 8'hDD);
        rst_n = 0;
        settle();
        pulse(1, 1);
        rst_n = 1;
        read_held("R1 reset after use", 8'h00, 8'h00);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        rst_n = 0; clk_ab = 0; clk_ba = 0;
        set_ctl(0, 0, 0, 1);
        drive(0, 8'h00, 0, 8'h00);
        a_line = 8'h00; b_line = 8'h00;
        t_reset();
        t_enables();
        t_isolation();
        t_live();
        t_capture_single();
        t_stored_vs_live();
        t_both_from_a();
        t_simultaneous();
        t_glitchless();
        t_hold();
        t_reset_again();
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

endmodule